// File: doc/BRIEF.md
# Indirect Command-Word Bus Bridge

This block lets software that only has a 64-bit register port reach a 32-bit-address internal bus. Software first loads a 32-bit write payload into a data register. It then writes one command word that carries a direction flag, a byte count and a target address. That single write starts exactly one internal bus transfer. When the transfer ends, the bridge posts a completion word, with read data for a read, into a status register. Reading the status register returns the word and clears it in the same access.

Before a transfer is issued, its target address is decoded against five fixed windows. A one-hot window select travels with the request, so that the neighbour on the bus can steer it. An address that hits no window is never put on the bus. It completes as a bus error. While a transfer is outstanding the bridge is busy, and any further command word is dropped.

Top module: `ibr_top`

## Requirements
- R1: The register port selects one of four 64-bit registers by `regAddr[4:3]`: 0 control, 1 reset, 2 status, 3 data. An access is accepted only when `regByteEn` is 8'hFF and `regAddr[2:0]` is zero. A rejected write changes nothing. A rejected read returns zero and has no side effect.
- R2: An accepted control write while idle starts a transfer. Bit 48 set means read and clear means write. Bits 59:56 are the byte count, driven on `busSize`. Bits 31:0 are the address, driven on `busAddr`. `busReq` then stays high until the cycle with `busAck`.
- R3: A control write whose byte count is greater than 8 is ignored. No request is made and the status register keeps its value.
- R4: A read that completes without `busErr` sets the status to bit 11 (done) plus `busRdata` placed at bits 57:26. `busRdata[31:24]` is byte 0 and is the most significant byte of that field.
- R5: A read that completes with `busErr` sets the status to bit 11 with bits 57:26 all ones.
- R6: A write drives the stored data register on `busWdata`, with byte 0 in bits 31:24, and drives `busWe` high. On completion the status is exactly bit 11, whether or not `busErr` is set.
- R7: An accepted status read returns the status word, and the register is zero from the next cycle on. Writes to the status register are ignored.
- R8: A data-register write stores `regWdata[63:32]`. A data read returns the stored value in bits 63:32 with bits 31:0 zero. Control and reset reads return zero.
- R9: `busWin` is one-hot alongside `busReq`. Bit 0 is I/O, 64 KiB at 0xD0010000. Bit 1 is firmware, 256 MiB at 0xF0000000. Bit 2 is memory, 256 MiB at 0xE0010000. Bit 3 is master registers, 0x60 bytes at 0xC0010000. Bit 4 is host-controller registers, 0x100 bytes at 0xC0012000. The lower bit wins where windows overlap, so firmware takes 0xF0000000 to 0xF000FFFF. An address outside every window makes no request and completes as a bus error two clock edges after the command.
- R10: A control write while a transfer is outstanding is dropped. The request in flight keeps its address, and no second transfer follows.
- R11: An accepted write to the reset register clears both the status and the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 5 | Register byte address |
| regByteEn | input | 8 | Byte enables; all must be set |
| regWdata | input | 64 | Register write value |
| regRdata | output | 64 | Register read value, valid while regRd is high |
| busReq | output | 1 | Internal bus request, held until busAck |
| busWe | output | 1 | 1 for a bus write |
| busAddr | output | 32 | Bus address |
| busSize | output | 4 | Byte count |
| busWdata | output | 32 | Write payload, byte 0 in bits 31:24 |
| busRdata | input | 32 | Read data, byte 0 in bits 31:24 |
| busAck | input | 1 | Transfer completes this cycle |
| busErr | input | 1 | Error flag qualified by busAck |
| busWin | output | 5 | One-hot decoded window of the request |

## Verification
A wrong command latch or window decode shows on `busAddr`, `busSize`, `busWe` or `busWin` in the first cycle of the request. A wrong completion word shows on the very next status read. A busy flag that fails to block a command shows as `busAddr` changing under a held request, or as a second request after the acknowledge. A status clear that misses shows on the second read of the same completion, which must return zero.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int NUM_WIN = 5;
  localparam int DONE_BIT = 11;
  localparam int RDATA_LSB = 26;
  localparam int RDIR_BIT = 48;
  localparam int SIZE_LSB = 56;
  localparam int MAX_BYTES = 8;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_RST = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  // index 0 has the highest priority: io, fw, mem, master, host
  localparam logic [NUM_WIN-1:0][31:0] WIN_BASE = {
    32'hC001_2000, 32'hC001_0000, 32'hE001_0000, 32'hF000_0000, 32'hD001_0000};
  localparam logic [NUM_WIN-1:0][31:0] WIN_SPAN = {
    32'h0000_0100, 32'h0000_0060, 32'h1000_0000, 32'h1000_0000, 32'h0001_0000};

  typedef struct packed {
    logic launch;
    logic finish;
    logic finishErr;
    logic clrStat;
    logic clrData;
    logic ldData;
  } ctlStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_FAULT} brState_t;
endpackage

// File: rtl/ibr_ctrl.sv
module ibr_ctrl
  import ibr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [4:0]         regAddr,
  input  logic [7:0]         regByteEn,
  input  logic [3:0]         cmdSizeIn,
  input  logic [31:0]        cmdAddrIn,
  input  logic               busAck,
  input  logic               busErr,
  output ctlStrobes_t        strobes,
  output logic [1:0]         regSel,
  output logic               readEn,
  output logic               busy,
  output logic               busReq,
  output logic [NUM_WIN-1:0] busWin
);
  brState_t state;
  logic [NUM_WIN-1:0] inWin, winPick, winReg;
  logic accOk, ctlWrite;

  assign accOk = (&regByteEn) && (regAddr[2:0] == 3'b000);
  assign regSel = regAddr[4:3];
  assign readEn = regRd && accOk;
  assign ctlWrite = regWr && accOk && (regSel == SEL_CTL);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign inWin[i] = (cmdAddrIn - WIN_BASE[i]) < WIN_SPAN[i];
  end
  assign winPick = inWin & ~(inWin - 1'b1);

  assign busy = (state != ST_IDLE);
  assign busReq = (state == ST_BUS);
  assign busWin = busReq ? winReg : '0;

  always_comb begin
    strobes = '0;
    strobes.launch = ctlWrite && !busy && (cmdSizeIn <= 4'(MAX_BYTES));
    strobes.finish = (busReq && busAck) || (state == ST_FAULT);
    strobes.finishErr = (busReq && busErr) || (state == ST_FAULT);
    strobes.clrStat = (readEn && regSel == SEL_STAT) ||
                      (regWr && accOk && regSel == SEL_RST);
    strobes.clrData = regWr && accOk && (regSel == SEL_RST);
    strobes.ldData = regWr && accOk && (regSel == SEL_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      winReg <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobes.launch) begin
          state <= (|winPick) ? ST_BUS : ST_FAULT;
          winReg <= winPick;
        end
        ST_BUS: if (busAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a request is held until acknowledged
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq);
  // R9: at most one window at a time
  p_win_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(busWin));
  // R9: no request leaves without a decoded window
  p_req_in_window_r9: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busWin != '0));
  // R10: a command while busy leaves the window of the request in flight untouched
  p_drop_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && ctlWrite |=> $stable(busWin) && busReq);
endmodule

// File: rtl/ibr_dp.sv
module ibr_dp
  import ibr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        busy,
  input  logic [1:0]  regSel,
  input  logic        readEn,
  input  logic [63:0] regWdata,
  input  logic [31:0] busRdata,
  output logic [63:0] regRdata,
  output logic        busWe,
  output logic [31:0] busAddr,
  output logic [3:0]  busSize,
  output logic [31:0] busWdata
);
  logic [63:0] statusReg, doneWord;
  logic [31:0] dataReg, rdField;
  logic cmdRead;

  assign rdField = strobes.finishErr ? 32'hFFFF_FFFF : busRdata;
  assign doneWord = (64'd1 << DONE_BIT) |
                    (cmdRead ? ({32'd0, rdField} << RDATA_LSB) : 64'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusReg <= '0;
      dataReg <= '0;
      cmdRead <= 1'b0;
      busAddr <= '0;
      busSize <= '0;
    end else begin
      if (strobes.finish) statusReg <= doneWord;
      else if (strobes.clrStat) statusReg <= '0;
      if (strobes.clrData) dataReg <= '0;
      else if (strobes.ldData) dataReg <= regWdata[63:32];
      if (strobes.launch) begin
        cmdRead <= regWdata[RDIR_BIT];
        busSize <= regWdata[SIZE_LSB+:4];
        busAddr <= regWdata[31:0];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    if (readEn) begin
      case (regSel)
        SEL_STAT: regRdata = statusReg;
        SEL_DATA: regRdata = {dataReg, 32'd0};
        default:  regRdata = '0;
      endcase
    end
  end

  assign busWe = !cmdRead;
  assign busWdata = dataReg;

  // R10: a launch never comes from the controller while it is busy
  p_launch_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.launch |-> !busy);
  // R4: every completion leaves the done flag visible
  p_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> statusReg[DONE_BIT]);
  // R2: the latched command cannot move while a transfer is outstanding
  p_cmd_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy && !strobes.finish |=> $stable(busAddr) && $stable(busSize));
endmodule

// File: rtl/ibr_top.sv
module ibr_top
  import ibr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [4:0]         regAddr,
  input  logic [7:0]         regByteEn,
  input  logic [63:0]        regWdata,
  output logic [63:0]        regRdata,
  output logic               busReq,
  output logic               busWe,
  output logic [31:0]        busAddr,
  output logic [3:0]         busSize,
  output logic [31:0]        busWdata,
  input  logic [31:0]        busRdata,
  input  logic               busAck,
  input  logic               busErr,
  output logic [NUM_WIN-1:0] busWin
);
  ctlStrobes_t strobes;
  logic [1:0] regSel;
  logic readEn, busy;

  ibr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regByteEn(regByteEn), .cmdSizeIn(regWdata[SIZE_LSB+:4]),
    .cmdAddrIn(regWdata[31:0]), .busAck(busAck), .busErr(busErr),
    .strobes(strobes), .regSel(regSel), .readEn(readEn), .busy(busy),
    .busReq(busReq), .busWin(busWin));

  ibr_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy), .regSel(regSel),
    .readEn(readEn), .regWdata(regWdata), .busRdata(busRdata),
    .regRdata(regRdata), .busWe(busWe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata));
endmodule

// File: tb/ibr_top_test.sv
module ibr_top_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWr = 0, regRd = 0;
  logic [4:0] regAddr = '0;
  logic [7:0] regByteEn = '0;
  logic [63:0] regWdata = '0, regRdata;
  logic busReq, busWe, busAck = 0, busErr = 0;
  logic [31:0] busAddr, busWdata, busRdata = '0;
  logic [3:0] busSize;
  logic [4:0] busWin;
  int nChk = 0, nBad = 0;

  always #5 clk = ~clk;

  ibr_top uut (.clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regByteEn(regByteEn), .regWdata(regWdata),
    .regRdata(regRdata), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .busErr(busErr), .busWin(busWin));

  typedef struct packed {
    logic rd; logic [3:0] size; logic [31:0] addr; logic [31:0] wd;
    logic [31:0] rdat; logic err; logic [4:0] win;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd4, 32'hD001_0004, 32'h0, 32'h1122_3344, 1'b0, 5'b00001},
    '{1'b1, 4'd2, 32'hE001_0000, 32'h0, 32'h5555_AAAA, 1'b1, 5'b00100},
    '{1'b0, 4'd4, 32'hF000_0010, 32'hCAFE_F00D, 32'h0, 1'b1, 5'b00010},
    '{1'b1, 4'd8, 32'hC001_0000, 32'h0, 32'hA5A5_0F0F, 1'b0, 5'b01000},
    '{1'b0, 4'd1, 32'hC001_20FC, 32'h1357_9BDF, 32'h0, 1'b0, 5'b10000},
    '{1'b1, 4'd4, 32'hC001_2100, 32'h0, 32'h0, 1'b0, 5'b00000},
    '{1'b1, 4'd4, 32'hC001_0060, 32'h0, 32'h0, 1'b0, 5'b00000},
    '{1'b0, 4'd0, 32'h0000_0000, 32'h0BAD_0BAD, 32'h0, 1'b0, 5'b00000}};

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] idx, logic [63:0] val, logic [7:0] be = 8'hFF);
    @(negedge clk);
    regWr = 1; regAddr = {idx, 3'b000}; regWdata = val; regByteEn = be;
    @(negedge clk);
    regWr = 0; regByteEn = 0;
  endtask

  task automatic rreg(logic [1:0] idx, output logic [63:0] val, input logic [7:0] be = 8'hFF);
    @(negedge clk);
    regRd = 1; regAddr = {idx, 3'b000}; regByteEn = be;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 0; regByteEn = 0;
  endtask

  function automatic logic [63:0] cmdWord(logic rd, logic [3:0] sz, logic [31:0] a);
    return (64'(sz) << 56) | (64'(rd) << 48) | 64'(a);
  endfunction

  function automatic logic [63:0] expStat(logic rd, logic err, logic [31:0] d);
    if (!rd) return 64'h800;
    return 64'h800 | ({32'd0, (err ? 32'hFFFF_FFFF : d)} << 26);
  endfunction

  task automatic ackBus(logic [31:0] d, logic e);
    busAck = 1; busErr = e; busRdata = d;
    @(negedge clk);
    busAck = 0; busErr = 0; busRdata = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state: R7 R8
    rreg(2'd2, v); check("R7 reset status", v, 64'd0);
    rreg(2'd3, v); check("R8 reset data", v, 64'd0);
    check("R2 reset busReq", {63'd0, busReq}, 64'd0);
    check("R9 reset busWin", {59'd0, busWin}, 64'd0);

    // table walk: R2 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      wreg(2'd3, {VEC[i].wd, 32'hFFFF_FFFF});
      wreg(2'd0, cmdWord(VEC[i].rd, VEC[i].size, VEC[i].addr));
      check($sformatf("R9 win v%0d", i), {59'd0, busWin}, {59'd0, VEC[i].win});
      if (VEC[i].win != 0) begin
        check($sformatf("R2 req v%0d", i), {63'd0, busReq}, 64'd1);
        check($sformatf("R2 addr v%0d", i), {32'd0, busAddr}, {32'd0, VEC[i].addr});
        check($sformatf("R2 size v%0d", i), {60'd0, busSize}, {60'd0, VEC[i].size});
        check($sformatf("R2 dir v%0d", i), {63'd0, busWe}, {63'd0, ~VEC[i].rd});
        if (!VEC[i].rd)
          check($sformatf("R6 wdata v%0d", i), {32'd0, busWdata}, {32'd0, VEC[i].wd});
        repeat (2) @(negedge clk);
        check($sformatf("R2 held v%0d", i), {63'd0, busReq}, 64'd1);
        ackBus(VEC[i].rdat, VEC[i].err);
        check($sformatf("R2 released v%0d", i), {63'd0, busReq}, 64'd0);
        rreg(2'd2, v);
        check($sformatf("R4 R5 R6 status v%0d", i), v,
              expStat(VEC[i].rd, VEC[i].err, VEC[i].rdat));
      end else begin
        check($sformatf("R9 no req v%0d", i), {63'd0, busReq}, 64'd0);
        @(negedge clk);
        check($sformatf("R9 no req later v%0d", i), {63'd0, busReq}, 64'd0);
        rreg(2'd2, v);
        check($sformatf("R9 miss status v%0d", i), v, expStat(VEC[i].rd, 1'b1, 32'h0));
      end
      rreg(2'd2, v);
      check($sformatf("R7 cleared v%0d", i), v, 64'd0);
    end

    // R8: data register read-back, control and reset read zero
    wreg(2'd3, 64'h1234_5678_9ABC_DEF0);
    rreg(2'd3, v); check("R8 data readback", v, 64'h1234_5678_0000_0000);
    rreg(2'd0, v); check("R8 control reads zero", v, 64'd0);
    rreg(2'd1, v); check("R8 reset reads zero", v, 64'd0);

    // R1: partial byte enables ignored for write and read
    wreg(2'd3, 64'hFFFF_FFFF_0000_0000, 8'h0F);
    rreg(2'd3, v); check("R1 partial write ignored", v, 64'h1234_5678_0000_0000);
    rreg(2'd3, v, 8'hF0); check("R1 partial read zero", v, 64'd0);
    @(negedge clk);
    regWr = 1; regAddr = 5'b11_100; regWdata = 64'h0; regByteEn = 8'hFF;
    @(negedge clk); regWr = 0; regByteEn = 0;
    rreg(2'd3, v); check("R1 misaligned ignored", v, 64'h1234_5678_0000_0000);

    // R6 R3: write op completes, then oversize command ignored
    wreg(2'd0, cmdWord(1'b0, 4'd4, 32'hD001_0000));
    check("R6 write payload", {32'd0, busWdata}, 64'h1234_5678);
    ackBus(32'h0, 1'b0);
    wreg(2'd0, cmdWord(1'b1, 4'd9, 32'hD001_0000));
    check("R3 no req", {63'd0, busReq}, 64'd0);
    @(negedge clk);
    check("R3 no req later", {63'd0, busReq}, 64'd0);
    // R7: write to status ignored
    wreg(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    rreg(2'd2, v); check("R3 R7 status kept", v, 64'h800);

    // R10: command while busy dropped
    wreg(2'd0, cmdWord(1'b1, 4'd4, 32'hD001_0000));
    wreg(2'd0, cmdWord(1'b0, 4'd2, 32'hE001_0000));
    check("R10 addr kept", {32'd0, busAddr}, 64'hD001_0000);
    check("R10 win kept", {59'd0, busWin}, 64'd1);
    ackBus(32'h0000_00FF, 1'b0);
    check("R10 no second req", {63'd0, busReq}, 64'd0);
    @(negedge clk);
    check("R10 still idle", {63'd0, busReq}, 64'd0);
    rreg(2'd2, v); check("R10 first status", v, expStat(1'b1, 1'b0, 32'h0000_00FF));

    // R11: reset register clears status and data
    wreg(2'd3, 64'hDEAD_BEEF_0000_0000);
    wreg(2'd0, cmdWord(1'b1, 4'd1, 32'h0000_0010));
    @(negedge clk);
    wreg(2'd1, 64'd0);
    rreg(2'd2, v); check("R11 status cleared", v, 64'd0);
    rreg(2'd3, v); check("R11 data cleared", v, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule